// File: doc/BRIEF.md
# ADC Serial Readout Controller

This block is the digital host-facing side of a 16-bit converter. It cycles through three phases: converting, sleeping in low power until the host asks for data, and shifting the result out. The analog core is replaced by a parallel result input. A conversion lasts a fixed number of system-clock cycles, set by a parameter. The result present on that input in the last conversion cycle is captured.

The host drives an active-low chip select and a serial clock, and reads serial data out most significant bit first. The serial clock may idle low or high. Only its falling edges advance the data, so both idle polarities read out the same way. Both host inputs pass through a synchronizer into the system-clock domain, and their edges are detected there.

A new conversion starts in two ways: on the falling serial-clock edge that follows the last bit, or when chip select rises during readout. When chip select rises, the bits not yet sent are dropped. Serial-clock activity during a conversion is ignored.

Top module: `adc_serial_readout`

## Requirements
- R1: After reset the controller is converting, with sdo_oe_o low and sdo_o low while chip select is high.
- R2: A conversion lasts CONV_CYCLES system-clock cycles. The value on core_result_i in its last cycle is captured. If synchronized chip select is then high, the controller goes to sleep.
- R3: A chip-select fall while sleeping starts readout. Bit 15 of the captured result appears on sdo_o three system clocks after the fall reaches the input, before any serial-clock edge.
- R4: During readout, each synchronized serial-clock falling edge moves sdo_o to the next lower bit. The order is bit 15 first, down to bit 0.
- R5: The falling edge that follows bit 0, which is the 16th fall, ends readout and starts a new conversion.
- R6: A chip-select rise during readout discards the unsent bits and starts a new conversion. The next readout delivers the new result.
- R7: With the serial clock held still, pulsing chip select low then high starts a new conversion.
- R8: Serial-clock rising edges never change the state or the bit shown. Readout works the same with the clock idling high or low.
- R9: Serial-clock edges during a conversion change neither its length nor the captured data.
- R10: sdo_oe_o is high exactly when synchronized chip select is low. This stands for a high-impedance output while chip select is high.
- R11: If chip select is already low when a conversion ends, readout begins at once, with bit 15 on sdo_o.
- R12: If a chip-select rise and the 16th serial-clock fall reach the controller in the same cycle, exactly one new conversion starts.
- R13: Outside readout, sdo_o is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Host chip select, active low, asynchronous |
| sck_i | input | 1 | Host serial clock, asynchronous, either idle level |
| core_result_i | input | DATA_W | Parallel result from the converter core |
| sdo_o | output | 1 | Serial data out, most significant bit first |
| sdo_oe_o | output | 1 | Output enable for sdo_o (low means high impedance) |

## Verification
A chip-select rise and the 16th serial-clock fall can land in the same system-clock cycle. The bench provokes this by changing both inputs at the same clock edge after fifteen falls, so both pass through identical synchronizers and arrive together. The outcome is judged by three things. The output enable must drop. A single conversion must follow: the cycle-accurate model shows exactly when the next result may appear. The next readout must return the value presented after the collision. A conversion end can also coincide with a chip-select fall. The per-cycle model covers that case, and the bench also checks the related case where chip select is held low through a whole conversion.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [1:0] {
        ST_CONVERT = 2'd0,
        ST_SLEEP   = 2'd1,
        ST_SHIFT   = 2'd2
    } rd_state_e;

endpackage

// File: rtl/adc_rd_sync.sv
module adc_rd_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d       = sync_q;
        sync_d.chain = {sync_q.chain[STAGES-2:0], async_i};
        sync_d.prev  = sync_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q.chain <= {STAGES{RST_VAL}};
            sync_q.prev  <= RST_VAL;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign level_o = sync_q.chain[STAGES-1];
    assign rise_o  = sync_q.chain[STAGES-1] & ~sync_q.prev;
    assign fall_o  = ~sync_q.chain[STAGES-1] & sync_q.prev;

endmodule

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
    parameter int CONV_CYCLES = 64,
    localparam int CNT_W      = $clog2(CONV_CYCLES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             done_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (run_i && (cnt_q != LAST)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o  = cnt_q;
    assign done_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic              clear_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              msb_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [DATA_W-1:0] word_o
);

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic [IDX_W-1:0]  idx;
    } shreg_t;

    shreg_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (clear_i) begin
            sh_d.word = '0;
            sh_d.idx  = '0;
        end else if (load_i) begin
            sh_d.word = data_i;
            sh_d.idx  = '0;
        end else if (shift_i) begin
            sh_d.word = {sh_q.word[DATA_W-2:0], 1'b0};
            sh_d.idx  = sh_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign msb_o  = sh_q.word[DATA_W-1];
    assign idx_o  = sh_q.idx;
    assign word_o = sh_q.word;

endmodule

// File: rtl/adc_serial_readout.sv
module adc_serial_readout
    import adc_rd_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int CONV_CYCLES = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sck_i,
    input  logic [DATA_W-1:0] core_result_i,
    output logic              sdo_o,
    output logic              sdo_oe_o
);

    localparam int CNT_W = $clog2(CONV_CYCLES);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);
    localparam int N_IN = 2;

    // host inputs: index 0 is chip select (idles high), index 1 is serial clock
    logic [N_IN-1:0] raw_in, lvl, rise, fall;
    assign raw_in = {sck_i, cs_n_i};

    for (genvar g = 0; g < N_IN; g++) begin : g_sync
        adc_rd_sync #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL ((g == 0) ? 1'b1 : 1'b0)
        ) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (raw_in[g]),
            .level_o (lvl[g]),
            .rise_o  (rise[g]),
            .fall_o  (fall[g])
        );
    end

    logic cs_lvl, cs_rise, cs_fall, sck_rise, sck_fall;
    assign cs_lvl   = lvl[0];
    assign cs_rise  = rise[0];
    assign cs_fall  = fall[0];
    assign sck_rise = rise[1];
    assign sck_fall = fall[1];

    typedef struct packed {
        rd_state_e state;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    logic             conv_done;
    logic [CNT_W-1:0] conv_cnt;
    logic             sh_load, sh_shift, sh_clear, sh_msb;
    logic [IDX_W-1:0] bit_idx;
    logic [DATA_W-1:0] sh_word;

    adc_rd_timer #(
        .CONV_CYCLES (CONV_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (fsm_q.state == ST_CONVERT),
        .cnt_o  (conv_cnt),
        .done_o (conv_done)
    );

    adc_rd_shifter #(
        .DATA_W (DATA_W)
    ) u_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (sh_load),
        .shift_i (sh_shift),
        .clear_i (sh_clear),
        .data_i  (core_result_i),
        .msb_o   (sh_msb),
        .idx_o   (bit_idx),
        .word_o  (sh_word)
    );

    always_comb begin
        fsm_d    = fsm_q;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        sh_clear = 1'b0;
        unique case (fsm_q.state)
            ST_CONVERT: begin
                if (conv_done) begin
                    sh_load     = 1'b1;
                    fsm_d.state = cs_lvl ? ST_SLEEP : ST_SHIFT;
                end
            end
            ST_SLEEP: begin
                if (cs_fall) begin
                    fsm_d.state = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                // chip-select rise wins over a coincident clock fall
                if (cs_rise) begin
                    sh_clear    = 1'b1;
                    fsm_d.state = ST_CONVERT;
                end else if (sck_fall) begin
                    if (bit_idx == LAST_IDX) begin
                        fsm_d.state = ST_CONVERT;
                    end else begin
                        sh_shift = 1'b1;
                    end
                end
            end
            default: fsm_d.state = ST_CONVERT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.state <= ST_CONVERT;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign sdo_o    = (fsm_q.state == ST_SHIFT) & sh_msb;
    assign sdo_oe_o = ~cs_lvl;

endmodule

// File: rtl/adc_serial_readout_chk.sv
module adc_serial_readout_chk
    import adc_rd_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int CONV_CYCLES = 64,
    localparam int CNT_W      = $clog2(CONV_CYCLES),
    localparam int IDX_W      = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input rd_state_e         state,
    input logic              cs_rise,
    input logic              cs_fall,
    input logic              sck_rise,
    input logic              sck_fall,
    input logic [CNT_W-1:0]  conv_cnt,
    input logic [IDX_W-1:0]  bit_idx,
    input logic [DATA_W-1:0] word
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CONV_CYCLES - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    assert_conv_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONVERT && conv_cnt == LAST_CNT) |=> (state != ST_CONVERT));

    assert_sleep_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && cs_fall) |=> (state == ST_SHIFT && bit_idx == '0));

    assert_shift_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && sck_fall && !cs_rise && bit_idx != LAST_IDX)
        |=> (state == ST_SHIFT && bit_idx == $past(bit_idx) + 1'b1
             && word == {$past(word[DATA_W-2:0]), 1'b0}));

    assert_last_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && sck_fall && bit_idx == LAST_IDX) |=> (state == ST_CONVERT));

    assert_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && cs_rise) |=> (state == ST_CONVERT && conv_cnt == '0));

    assert_rise_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && sck_rise && !cs_rise) |=> (state == ST_SHIFT && $stable(bit_idx)));

    assert_conv_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONVERT && conv_cnt != LAST_CNT) |=> $stable(word));

endmodule

bind adc_serial_readout adc_serial_readout_chk #(
    .DATA_W      (DATA_W),
    .CONV_CYCLES (CONV_CYCLES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (fsm_q.state),
    .cs_rise  (cs_rise),
    .cs_fall  (cs_fall),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .conv_cnt (conv_cnt),
    .bit_idx  (bit_idx),
    .word     (sh_word)
);

// File: tb/adc_serial_readout_bench.sv
module adc_serial_readout_bench;

    localparam int DW   = 16;
    localparam int CONV = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          sck = 1'b0;
    logic [DW-1:0] core = '0;
    logic          sdo, sdo_oe;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    adc_serial_readout #(
        .DATA_W      (DW),
        .CONV_CYCLES (CONV),
        .SYNC_STAGES (2)
    ) u_adc_serial_readout (
        .clk           (clk),
        .rst_n         (rst_n),
        .cs_n_i        (cs_n),
        .sck_i         (sck),
        .core_result_i (core),
        .sdo_o         (sdo),
        .sdo_oe_o      (sdo_oe)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference: two-flop delay on host inputs, bit queue for data
    int m_state = 0; // 0 converting, 1 sleeping, 2 reading
    int m_cnt = 0;
    bit m_cs1 = 1, m_cs2 = 1, m_csp = 1;
    bit m_sk1 = 0, m_sk2 = 0, m_skp = 0;
    bit m_bits[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_cnt = 0;
            m_cs1 = 1; m_cs2 = 1; m_csp = 1;
            m_sk1 = 0; m_sk2 = 0; m_skp = 0;
            m_bits.delete();
        end else begin
            bit c_rise, c_fall, k_fall;
            c_rise = m_cs2 && !m_csp;
            c_fall = !m_cs2 && m_csp;
            k_fall = !m_sk2 && m_skp;
            case (m_state)
                0: if (m_cnt == CONV - 1) begin
                       m_cnt = 0;
                       m_bits.delete();
                       for (int i = DW - 1; i >= 0; i--) m_bits.push_back(core[i]);
                       m_state = m_cs2 ? 1 : 2;
                   end else m_cnt++;
                1: if (c_fall) m_state = 2;
                default: if (c_rise) begin
                       m_state = 0; m_bits.delete();
                   end else if (k_fall) begin
                       if (m_bits.size() <= 1) m_state = 0;
                       else void'(m_bits.pop_front());
                   end
            endcase
            m_csp = m_cs2; m_cs2 = m_cs1; m_cs1 = cs_n;
            m_skp = m_sk2; m_sk2 = m_sk1; m_sk1 = sck;
        end
        #2;
        check(m_state == 2 ? "R4 per-cycle sdo" : "R13 per-cycle sdo",
              int'(sdo), (m_state == 2 && m_bits.size() > 0) ? int'(m_bits[0]) : 0);
        check("R10 per-cycle oe", int'(sdo_oe), int'(!m_cs2));
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one serial clock pulse; returns after the fall has settled
    task automatic pulse(input bit cpol);
        if (cpol) begin
            sck = 1'b0; cyc(4);
        end else begin
            sck = 1'b1; cyc(3);
            sck = 1'b0; cyc(4);
        end
    endtask

    task automatic pulse_tail(input bit cpol);
        if (cpol) begin
            sck = 1'b1; cyc(3);
        end
    endtask

    // samples bit 15, then 15 falls; the 16th fall is left to the caller
    task automatic read_word(input bit cpol, output logic [DW-1:0] w);
        w[DW-1] = sdo;
        for (int i = DW - 2; i >= 0; i--) begin
            pulse(cpol);
            w[i] = sdo;
            pulse_tail(cpol);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] w;
        cyc(3);
        check("R1 oe in reset", int'(sdo_oe), 0);
        check("R1 sdo in reset", int'(sdo), 0);
        rst_n = 1'b1;
        core = 16'hA5C3;
        cyc(CONV + 6);
        check("R13 sleeping sdo low", int'(sdo), 0);
        cs_n = 1'b0; cyc(4);
        check("R3 D15 before clock", int'(sdo), 1);
        check("R10 oe with cs low", int'(sdo_oe), 1);
        read_word(1'b0, w);
        check("R4 word cpol0", int'(w), 16'hA5C3);
        core = 16'hC35A;
        pulse(1'b0);
        check("R5 restart after 16th fall", int'(sdo), 0);
        check("R5 oe stays", int'(sdo_oe), 1);
        cyc(CONV - 8);
        check("R2 still converting", int'(sdo), 0);
        cyc(8);
        check("R11 direct readout D15", int'(sdo), 1);
        // abort after three bits
        pulse(1'b0); pulse(1'b0); pulse(1'b0);
        cs_n = 1'b1; core = 16'h1234; cyc(4);
        check("R10 oe off after cs high", int'(sdo_oe), 0);
        for (int i = 0; i < 5; i++) pulse(1'b0);   // R9 clocks during conversion
        cyc(CONV + 6);
        cs_n = 1'b0; cyc(4);
        read_word(1'b0, w);
        check("R6 R9 new result after abort", int'(w), 16'h1234);
        core = 16'h8001;
        pulse(1'b0);
        cyc(2); cs_n = 1'b1;
        cyc(CONV + 6);
        cs_n = 1'b0; cyc(4);
        check("R3 sleep wake D15", int'(sdo), 1);
        cs_n = 1'b1; cyc(2);
        core = 16'h7FFE;
        cyc(CONV + 6);
        cs_n = 1'b0; cyc(4);
        check("R7 cs-only pulse restarted", int'(sdo), 0);
        sck = 1'b1; cyc(4);
        check("R8 rise leaves D15", int'(sdo), 0);
        read_word(1'b1, w);
        check("R8 word cpol1", int'(w), 16'h7FFE);
        // 16th fall together with chip-select rise
        sck = 1'b0; cs_n = 1'b1; cyc(4);
        check("R12 oe off", int'(sdo_oe), 0);
        core = 16'h0F0F;
        sck = 1'b1;
        cyc(CONV + 6);
        cs_n = 1'b0; cyc(4);
        read_word(1'b1, w);
        check("R12 single restart result", int'(w), 16'h0F0F);
        sck = 1'b0; cyc(4);
        check("R5 end of cpol1 read", int'(sdo), 0);
        cs_n = 1'b1; cyc(6);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule